// File: doc/BRIEF.md
# SYSREF Divider with Global and Per-Output Delay

This block makes a group of low-rate reference pulse trains (SYSREF outputs) from one fast clock. A single programmable counter divides the clock by any whole ratio from 8 to 8191, odd or even. The divided signal first goes through one global delay line that moves the phase of every output together. Each output then has its own delay line, which sets its phase separately.

The block runs at twice the distribution rate, so one clock tick is half a distribution cycle. A local delay is set as a whole number of distribution cycles plus an optional half-cycle bit, which gives 3 to 22 ticks (1.5 to 11 cycles).

All settings are staged. The divide ratio, global delay and local delays on the inputs only take effect on a sync pulse. The same pulse restarts the divider and clears every delay line, so all outputs realign to a known phase.

Top module: `sysref_dly_gen`

## Requirements
- R1: Synchronous active-low reset drives every output low. It then applies default settings: ratio 8, global delay 0, local delay 3 ticks on every output. The divider then starts exactly as after a sync pulse.
- R2: With an applied ratio N, each output repeats every N ticks. It is high for ceil(N/2) ticks and low for floor(N/2) ticks, so an odd ratio gives a high phase one tick longer than the low phase.
- R3: A requested ratio below 8 is applied as 8. A requested ratio above 8191 (the ratio input is 14 bits wide) is applied as 8191.
- R4: The global delay input, G ticks (0 to 15), delays every output by G ticks.
- R5: Each output's local delay, in ticks, is twice its 4-bit cycle field plus its half-step bit. The result is clamped to the range 3 to 22 ticks. Output k uses cycle-field bits [4k+3:4k] and half-step bit k.
- R6: Setting an output's half-step bit adds exactly one tick to that output's delay and leaves the other outputs unchanged.
- R7: Changes on the ratio, global delay and local delay inputs have no effect on the outputs until a sync pulse is sampled high.
- R8: On a clock edge where sync is high, the divider restarts and all delay lines clear. With total delay D = G + local ticks, output k stays low for D ticks after that edge and rises on the (D+1)-th edge.
- R9: All outputs come from the same divider, so outputs with equal local settings are identical on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the distribution rate |
| rst_n | input | 1 | Synchronous active-low reset |
| sync | input | 1 | Applies staged settings and realigns the divider and delays |
| div_cfg | input | 14 | Requested divide ratio |
| gdly_cfg | input | 4 | Global delay in ticks |
| lcyc_cfg | input | 16 | Per-output local delay in whole distribution cycles, 4 bits per output |
| lhalf_cfg | input | 4 | Per-output half-step enable |
| sysref_out | output | 4 | SYSREF outputs |

## Verification
The assertions take three things for granted: sync is a synchronous one-tick pulse, the configuration inputs are stable around each clock edge, and reset is applied for at least one edge before any check. The hold property also assumes that nothing except a sampled sync pulse or reset may change the applied settings. The stimulus changes inputs only on falling edges and raises sync for single ticks only. Its staged values include illegal ratios and local fields, but it never moves anything within half a tick of a rising edge.

// File: rtl/sysref_pkg.sv
// Package: shared default limits for the SYSREF divider/delay block.
// Assumes the clock runs at twice the distribution rate (one tick = half cycle).
package sysref_pkg;
    localparam int SR_NUM_OUT  = 4;
    localparam int SR_DIV_MIN  = 8;
    localparam int SR_DIV_MAX  = 8191;
    localparam int SR_DIV_IN_W = 14;
    localparam int SR_GDLY_W   = 4;
    localparam int SR_LCYC_W   = 4;
    localparam int SR_LOC_MIN  = 3;
    localparam int SR_LOC_MAX  = 22;
endpackage

// File: rtl/sysref_cfg_stage.sv
// sysref_cfg_stage: clamps the requested settings and holds the applied copy.
// The applied copy changes only on reset (defaults) or on a sampled sync pulse.
// Assumes the configuration inputs are stable at the sampling edge.
module sysref_cfg_stage #(
    parameter int NUM_OUT  = 4,
    parameter int DIV_IN_W = 14,
    parameter int CNT_W    = 13,
    parameter int DIV_MIN  = 8,
    parameter int DIV_MAX  = 8191,
    parameter int GDLY_W   = 4,
    parameter int LCYC_W   = 4,
    parameter int LT_W     = 5,
    parameter int LOC_MIN  = 3,
    parameter int LOC_MAX  = 22
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              sync,
    input  logic [DIV_IN_W-1:0]               div_cfg,
    input  logic [GDLY_W-1:0]                 gdly_cfg,
    input  logic [NUM_OUT*LCYC_W-1:0]         lcyc_cfg,
    input  logic [NUM_OUT-1:0]                lhalf_cfg,
    output logic [CNT_W-1:0]                  div_act,
    output logic [GDLY_W-1:0]                 gdly_act,
    output logic [NUM_OUT-1:0][LT_W-1:0]      lt_act
);
    localparam int RAW_W = LCYC_W + 2;

    logic [CNT_W-1:0]             div_nx;
    logic [NUM_OUT-1:0][LT_W-1:0] lt_nx;

    // Clamp the requested ratio into the legal range.
    always_comb begin
        if (div_cfg < DIV_IN_W'(DIV_MIN))
            div_nx = CNT_W'(DIV_MIN);
        else if (div_cfg > DIV_IN_W'(DIV_MAX))
            div_nx = CNT_W'(DIV_MAX);
        else
            div_nx = div_cfg[CNT_W-1:0];
    end

    // Turn each cycle field plus half bit into ticks, clamped to the legal window.
    always_comb begin
        for (int i = 0; i < NUM_OUT; i++) begin
            logic [RAW_W-1:0] raw;
            raw = {1'b0, lcyc_cfg[i*LCYC_W +: LCYC_W], 1'b0} + RAW_W'(lhalf_cfg[i]);
            if (raw < RAW_W'(LOC_MIN))
                lt_nx[i] = LT_W'(LOC_MIN);
            else if (raw > RAW_W'(LOC_MAX))
                lt_nx[i] = LT_W'(LOC_MAX);
            else
                lt_nx[i] = raw[LT_W-1:0];
        end
    end

    // Hold the applied settings; load defaults on reset, staged values on sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_act  <= CNT_W'(DIV_MIN);
            gdly_act <= '0;
            for (int i = 0; i < NUM_OUT; i++) lt_act[i] <= LT_W'(LOC_MIN);
        end else if (sync) begin
            div_act  <= div_nx;
            gdly_act <= gdly_cfg;
            lt_act   <= lt_nx;
        end
    end

    assert_ratio_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (div_act >= CNT_W'(DIV_MIN)) && (div_act <= CNT_W'(DIV_MAX)));

    assert_settings_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sync |=> $stable(div_act) && $stable(gdly_act) && $stable(lt_act));

    // R5: every applied local delay sits inside the tick window
    always_comb begin
        if (rst_n) begin
            for (int i = 0; i < NUM_OUT; i++) begin
                assert_ticks_window_R5: assert ((lt_act[i] >= LT_W'(LOC_MIN)) && (lt_act[i] <= LT_W'(LOC_MAX)));
            end
        end
    end
endmodule

// File: rtl/sysref_div_core.sv
// sysref_div_core: shared ratio-N divider. Output is high for ceil(N/2) ticks,
// then low for floor(N/2). Reset and sync restart the count with the output low.
// Assumes N >= 2 (the staging stage guarantees N >= 8).
module sysref_div_core #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync,
    input  logic [CNT_W-1:0] div_n,
    output logic             div_q
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   hi_len;
    logic             at_last;

    // Length of the high phase and the end-of-period flag.
    always_comb begin
        hi_len  = ({1'b0, div_n} + (CNT_W+1)'(1)) >> 1;
        at_last = (cnt == div_n - CNT_W'(1));
    end

    // Advance the phase counter and register the divided level.
    always_ff @(posedge clk) begin
        if (!rst_n || sync) begin
            cnt   <= '0;
            div_q <= 1'b0;
        end else begin
            cnt   <= at_last ? '0 : cnt + CNT_W'(1);
            div_q <= ({1'b0, cnt} < hi_len);
        end
    end

    assert_count_below_ratio_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < div_n);

    assert_rise_at_period_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_q) |-> (cnt == CNT_W'(1)));
endmodule

// File: rtl/sysref_tap_delay.sv
// sysref_tap_delay: tapped shift line. The output equals the input delayed by
// 'sel' ticks (sel = 0 passes the input straight through). Reset and sync clear the line.
// Assumes sel <= LEN.
module sysref_tap_delay #(
    parameter int LEN   = 15,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync,
    input  logic [SEL_W-1:0] sel,
    input  logic             din,
    output logic             dout
);
    logic [LEN-1:0] line;

    // Shift the input along the line; clear on reset or realignment.
    always_ff @(posedge clk) begin
        if (!rst_n || sync)
            line <= '0;
        else
            line <= {line[LEN-2:0], din};
    end

    // Pick the tap that matches the requested delay.
    always_comb begin
        dout = din;
        for (int i = 0; i < LEN; i++) begin
            if (sel == SEL_W'(i + 1)) dout = line[i];
        end
    end
endmodule

// File: rtl/sysref_dly_gen.sv
// sysref_dly_gen: SYSREF generator top. One shared divider feeds a global delay
// line, then one local delay line per output. Settings are staged and take
// effect on sync. Assumes sync is a synchronous single-tick pulse.
module sysref_dly_gen
    import sysref_pkg::*;
#(
    parameter int NUM_OUT  = SR_NUM_OUT,
    parameter int DIV_MIN  = SR_DIV_MIN,
    parameter int DIV_MAX  = SR_DIV_MAX,
    parameter int DIV_IN_W = SR_DIV_IN_W,
    parameter int GDLY_W   = SR_GDLY_W,
    parameter int LCYC_W   = SR_LCYC_W,
    parameter int LOC_MIN  = SR_LOC_MIN,
    parameter int LOC_MAX  = SR_LOC_MAX
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sync,
    input  logic [DIV_IN_W-1:0]       div_cfg,
    input  logic [GDLY_W-1:0]         gdly_cfg,
    input  logic [NUM_OUT*LCYC_W-1:0] lcyc_cfg,
    input  logic [NUM_OUT-1:0]        lhalf_cfg,
    output logic [NUM_OUT-1:0]        sysref_out
);
    localparam int CNT_W   = $clog2(DIV_MAX + 1);
    localparam int LT_W    = $clog2(LOC_MAX + 1);
    localparam int GDLY_LEN = (1 << GDLY_W) - 1;

    logic [CNT_W-1:0]             div_act;
    logic [GDLY_W-1:0]            gdly_act;
    logic [NUM_OUT-1:0][LT_W-1:0] lt_act;
    logic                         div_q;
    logic                         glob_q;

    sysref_cfg_stage #(
        .NUM_OUT(NUM_OUT), .DIV_IN_W(DIV_IN_W), .CNT_W(CNT_W),
        .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX), .GDLY_W(GDLY_W),
        .LCYC_W(LCYC_W), .LT_W(LT_W), .LOC_MIN(LOC_MIN), .LOC_MAX(LOC_MAX)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .sync(sync),
        .div_cfg(div_cfg), .gdly_cfg(gdly_cfg),
        .lcyc_cfg(lcyc_cfg), .lhalf_cfg(lhalf_cfg),
        .div_act(div_act), .gdly_act(gdly_act), .lt_act(lt_act)
    );

    sysref_div_core #(.CNT_W(CNT_W)) u_div (
        .clk(clk), .rst_n(rst_n), .sync(sync),
        .div_n(div_act), .div_q(div_q)
    );

    sysref_tap_delay #(.LEN(GDLY_LEN), .SEL_W(GDLY_W)) u_glob (
        .clk(clk), .rst_n(rst_n), .sync(sync),
        .sel(gdly_act), .din(div_q), .dout(glob_q)
    );

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_local
        sysref_tap_delay #(.LEN(LOC_MAX), .SEL_W(LT_W)) u_loc (
            .clk(clk), .rst_n(rst_n), .sync(sync),
            .sel(lt_act[k]), .din(glob_q), .dout(sysref_out[k])
        );
    end

    assert_quiet_after_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sync) && $past(rst_n)) |-> (sysref_out == '0));
endmodule

// File: tb/tb_sysref_dly_gen.sv
`timescale 1ns/1ps
// Self-checking bench: a behavioural tick-count model predicts every output
// on every clock and is compared at the falling edge.
module tb_sysref_dly_gen;
    localparam int NO = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sync = 1'b0;
    logic [13:0]     div_cfg = 14'd8;
    logic [3:0]      gdly_cfg = 4'd0;
    logic [NO*4-1:0] lcyc_cfg = '0;
    logic [NO-1:0]   lhalf_cfg = '0;
    logic [NO-1:0]   sysref_out;

    int checks = 0;
    int failures = 0;
    bit checking = 0;
    bit pair_check = 0;
    string tag = "R1";

    // Model state: ticks since the last restart and the applied settings.
    int e = 0, mN = 8, mG = 0;
    int mL [NO] = '{3, 3, 3, 3};

    sysref_dly_gen dut (
        .clk(clk), .rst_n(rst_n), .sync(sync), .div_cfg(div_cfg),
        .gdly_cfg(gdly_cfg), .lcyc_cfg(lcyc_cfg), .lhalf_cfg(lhalf_cfg),
        .sysref_out(sysref_out)
    );

    always #2.5 clk = ~clk;

    function automatic int clamp(int v, int lo, int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    function automatic bit exp_bit(int k);
        int p = e - mG - mL[k];
        if (p < 1) return 1'b0;
        return (((p - 1) % mN) < ((mN + 1) / 2));
    endfunction

    // Reference model update at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            e = 0; mN = 8; mG = 0;
            for (int k = 0; k < NO; k++) mL[k] = 3;
        end else if (sync) begin
            e = 0;
            mN = clamp(int'(div_cfg), 8, 8191);
            mG = int'(gdly_cfg);
            for (int k = 0; k < NO; k++)
                mL[k] = clamp(2 * int'(lcyc_cfg[k*4 +: 4]) + int'(lhalf_cfg[k]), 3, 22);
        end else begin
            e = e + 1;
        end
    end

    // Compare outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (checking) begin
            logic [NO-1:0] exp_v;
            for (int k = 0; k < NO; k++) exp_v[k] = exp_bit(k);
            checks++;
            if (sysref_out !== exp_v) begin
                failures++;
                $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, sysref_out, exp_v);
            end
            if (pair_check) begin
                checks++;
                if (sysref_out[0] !== sysref_out[3]) begin
                    failures++;
                    $display("FAIL R9 t=%0t actual=%b expected=%b", $time, sysref_out[3], sysref_out[0]);
                end
            end
        end
    end

    task automatic stage(input int n, input int g, input logic [15:0] cyc, input logic [3:0] half);
        div_cfg = 14'(n); gdly_cfg = 4'(g); lcyc_cfg = cyc; lhalf_cfg = half;
    endtask

    task automatic pulse_sync();
        @(negedge clk); sync = 1'b1;
        @(negedge clk); sync = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: outputs low in reset, then default waveform (ratio 8, delay 3).
        @(posedge clk);
        checking = 1;
        tag = "R1";
        run(4);
        rst_n = 1'b1;
        run(40);

        // R5/R6: local clamp low (field 1, no half -> 3), half step, max, mid.
        tag = "R5";
        stage(8, 0, {4'd5, 4'd11, 4'd1, 4'd1}, 4'b1001);
        pulse_sync();
        run(100);
        tag = "R6";
        stage(8, 0, {4'd5, 4'd11, 4'd1, 4'd1}, 4'b1011);
        pulse_sync();
        run(100);

        // R2/R4: odd ratio with global delay.
        tag = "R2";
        stage(9, 5, {4'd2, 4'd3, 4'd4, 4'd2}, 4'b0100);
        pulse_sync();
        run(120);
        tag = "R4";
        stage(9, 15, {4'd2, 4'd3, 4'd4, 4'd2}, 4'b0100);
        pulse_sync();
        run(120);

        // R9: outputs 0 and 3 set identically.
        tag = "R9";
        pair_check = 1;
        stage(13, 3, {4'd6, 4'd2, 4'd9, 4'd6}, 4'b1001);
        pulse_sync();
        run(150);
        pair_check = 0;

        // R3: ratio below the minimum, then above the maximum; local field over range.
        tag = "R3";
        stage(3, 2, {4'd15, 4'd15, 4'd0, 4'd7}, 4'b1100);
        pulse_sync();
        run(80);
        stage(16000, 1, {4'd1, 4'd2, 4'd3, 4'd4}, 4'b0000);
        pulse_sync();
        run(17000);

        // R7: change staged inputs without sync; outputs must keep the old pattern.
        tag = "R7";
        stage(10, 0, {4'd3, 4'd3, 4'd3, 4'd3}, 4'b0000);
        pulse_sync();
        run(30);
        stage(21, 9, {4'd11, 4'd1, 4'd7, 4'd5}, 4'b1111);
        run(80);

        // R8: sync in mid-period realigns with the newly staged values.
        tag = "R8";
        run(3);
        pulse_sync();
        run(120);
        stage(11, 4, {4'd1, 4'd10, 4'd4, 4'd8}, 4'b0110);
        run(5);
        pulse_sync();
        run(120);

        // R1: reset again in mid-run, then defaults.
        tag = "R1";
        @(negedge clk); rst_n = 1'b0;
        run(3);
        rst_n = 1'b1;
        run(40);

        checking = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule